// File: doc/BRIEF.md
# Crystal-to-10 Hz Time Base Divider

This block turns a 32768 Hz crystal clock into a 10 Hz time base for a calendar clock. It runs entirely on the crystal clock and emits a short setting pulse, one crystal period wide, ten times a second. The counters that keep time are advanced by this pulse.

The division has three stages in series:

- A pulse-swallowing stage drops one crystal cycle in every sixteen, so 30720 of each 32768 cycles advance the next stage.
- A binary counter divides those advance cycles by 512, giving 60 Hz.
- A Johnson counter divides the 60 Hz carries by six.

The output is registered. A stop input clears the whole chain and holds it cleared. When the stop input is released, counting starts again from zero.

Top module: `xtal_tick_divider`

## Requirements
- R1: While `rst` is high, `tick_o` is low. After reset release, the first pulse is visible after the 3276th rising edge, counting the first edge with `rst` low as edge 0 (index 3275).
- R2: The swallowing stage blocks exactly one crystal cycle out of every 16. No two consecutive cycles are blocked. Cycle index k (edges since release) is blocked when (k+1) mod 16 equals 0.
- R3: The binary stage counts 512 advance cycles. It carries on the advance that wraps it from 511 to 0.
- R4: The Johnson stage steps through six states, 000→001→011→111→110→100→000. It emits its carry on the step out of state 100. An illegal state returns to 000 on the next clock.
- R5: `tick_o` is high for exactly one clock and never on two consecutive clocks.
- R6: Let N(k) = (k+1) − floor((k+1)/16). After edge k, `tick_o` is high exactly when (k+1) mod 16 ≠ 0 and N(k) is a multiple of 3072.
- R7: Running C edges from release produces exactly floor(N(C−1)/3072) pulses. This gives 10 pulses per 32768 cycles.
- R8: Consecutive pulses are spaced 3276 or 3277 clocks apart.
- R9: While `halt_i` is high, all stages are held cleared and `tick_o` stays low. After release, counting restarts from zero, so the first pulse again appears at index 3275.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Stop control; clears and holds the divider chain |
| tick_o | output | 1 | Registered 10 Hz setting pulse, one clock wide |

## Verification
The chain's terminal condition is evaluated combinationally from the stage registers before an edge. `tick_o` takes that value at the same edge, so a pulse is due on the clock right after edge k, where k is the edge at which N(k) reaches a multiple of 3072. The bench counts edges since the release of `rst` or `halt_i`. It samples `tick_o` on the falling edge after every rising edge and compares it with the R6 formula on every single cycle. Pulse counts, spacing and width are collected from the same falling-edge samples.

// File: rtl/xtal_div_pkg.sv
package xtal_div_pkg;
  localparam int DEF_SWALLOW_PERIOD = 16;
  localparam int DEF_BIN_BITS       = 9;
  localparam int DEF_JC_STAGES      = 3;
endpackage

// File: rtl/swallow_stage.sv
module swallow_stage #(
  parameter int PERIOD = xtal_div_pkg::DEF_SWALLOW_PERIOD
) (
  input  logic clk,
  input  logic clr,
  output logic adv_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // one blocked cycle per period
  assign adv_o = (phase_q != LAST);

  // R2
  swallow_gap_chk: assert property (@(posedge clk) disable iff (clr)
    !adv_o |=> adv_o);
endmodule

// File: rtl/binary_stage.sv
module binary_stage #(
  parameter int BITS = xtal_div_pkg::DEF_BIN_BITS
) (
  input  logic clk,
  input  logic clr,
  input  logic adv_i,
  output logic carry_o
);
  logic [BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carry_o = adv_i && (&cnt_q);

  // R3
  bin_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    carry_o |=> (cnt_q == '0));
endmodule

// File: rtl/johnson_stage.sv
module johnson_stage #(
  parameter int STAGES = xtal_div_pkg::DEF_JC_STAGES
) (
  input  logic clk,
  input  logic clr,
  input  logic adv_i,
  output logic carry_o
);
  localparam logic [STAGES-1:0] TERM = {1'b1, {(STAGES-1){1'b0}}};

  logic [STAGES-1:0] ring_q;
  logic              legal;

  // legal states have at most one boundary between adjacent bits
  always_comb begin
    int edges;
    edges = 0;
    for (int i = 0; i < STAGES - 1; i++) begin
      if (ring_q[i] != ring_q[i+1]) edges++;
    end
    legal = (edges <= 1);
  end

  always_ff @(posedge clk) begin
    if (clr || !legal) begin
      ring_q <= '0;
    end else if (adv_i) begin
      ring_q <= {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
    end
  end

  assign carry_o = adv_i && (ring_q == TERM);

  // R4
  jc_legal_chk: assert property (@(posedge clk) disable iff (clr)
    !legal |=> legal);
  // R4
  jc_step_chk: assert property (@(posedge clk) disable iff (clr)
    legal |=> ($countones(ring_q ^ $past(ring_q)) <= 1));
  // R4
  jc_term_chk: assert property (@(posedge clk) disable iff (clr)
    carry_o |=> (ring_q == '0));
endmodule

// File: rtl/xtal_tick_divider.sv
module xtal_tick_divider #(
  parameter int SWALLOW_PERIOD = xtal_div_pkg::DEF_SWALLOW_PERIOD,
  parameter int BIN_BITS       = xtal_div_pkg::DEF_BIN_BITS,
  parameter int JC_STAGES      = xtal_div_pkg::DEF_JC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  output logic tick_o
);
  logic clr;
  logic adv_s1;
  logic carry_s2;
  logic carry_s3;

  assign clr = rst | halt_i;

  swallow_stage #(.PERIOD(SWALLOW_PERIOD)) u_swallow (
    .clk   (clk),
    .clr   (clr),
    .adv_o (adv_s1)
  );

  binary_stage #(.BITS(BIN_BITS)) u_binary (
    .clk     (clk),
    .clr     (clr),
    .adv_i   (adv_s1),
    .carry_o (carry_s2)
  );

  johnson_stage #(.STAGES(JC_STAGES)) u_johnson (
    .clk     (clk),
    .clr     (clr),
    .adv_i   (carry_s2),
    .carry_o (carry_s3)
  );

  // registered setting pulse, one crystal period wide
  always_ff @(posedge clk) begin
    if (clr) begin
      tick_o <= 1'b0;
    end else begin
      tick_o <= carry_s3;
    end
  end

  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (clr)
    tick_o |=> !tick_o);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !tick_o);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !tick_o);
endmodule

// File: tb/test_xtal_tick_divider.sv
module test_xtal_tick_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_i = 1'b0;
  logic tick_o;

  int n_tests = 0;
  int n_fail  = 0;
  int k_idx   = 0;
  int ticks, mism, dbl, gap_bad, first_at, last_at;
  logic prev_tick;
  int cyc = 0;

  always #2 clk = ~clk;

  xtal_tick_divider i_xtal_tick_divider (
    .clk    (clk),
    .rst    (rst),
    .halt_i (halt_i),
    .tick_o (tick_o)
  );

  // cycles run since reset release, count of expected pulses
  localparam int NVEC = 6;
  localparam int VEC [NVEC][2] = '{
    '{3275, 0}, '{3276, 1}, '{6552, 1},
    '{6553, 2}, '{32768, 10}, '{65536, 20}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expect_tick(input int k);
    int n;
    n = (k + 1) - (k + 1) / 16;
    return ((k + 1) % 16 != 0) && (n % 3072 == 0);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    halt_i = 1'b0;
    repeat (3) @(negedge clk);
    check(tick_o == 1'b0, "R1 tick low in reset", int'(tick_o), 0);
    rst = 1'b0;
    k_idx = 0;
  endtask

  task automatic run(input int n);
    ticks = 0; mism = 0; dbl = 0; gap_bad = 0;
    first_at = -1; last_at = -1; prev_tick = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (tick_o !== expect_tick(k_idx)) mism++;
      if (tick_o) begin
        ticks++;
        if (prev_tick) dbl++;
        if (first_at < 0) first_at = k_idx;
        if (last_at >= 0 && (k_idx - last_at) != 3276 && (k_idx - last_at) != 3277)
          gap_bad++;
        last_at = k_idx;
      end
      prev_tick = tick_o;
      k_idx++;
    end
  endtask

  initial begin
    for (int i = 0; i < 195000; i++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      run(VEC[v][0]);
      check(ticks == VEC[v][1], "R7 pulse count", ticks, VEC[v][1]);
      check(mism == 0, "R6 R2 R3 R4 per-cycle timing", mism, 0);
      check(dbl == 0, "R5 single-cycle width", dbl, 0);
      check(gap_bad == 0, "R8 pulse spacing", gap_bad, 0);
    end

    // first pulse position after reset
    do_reset();
    run(3276);
    check(first_at == 3275, "R1 first pulse index", first_at, 3275);

    // halt mid-count
    do_reset();
    run(2000);
    @(negedge clk);
    halt_i = 1'b1;
    ticks = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tick_o) ticks++;
    end
    check(ticks == 0, "R9 no pulse while halted", ticks, 0);
    halt_i = 1'b0;
    k_idx = 0;
    run(3276);
    check(first_at == 3275, "R9 restart from zero", first_at, 3275);
    check(mism == 0, "R9 timing after halt", mism, 0);

    // reset asserted in mid-count
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(tick_o == 1'b0, "R1 reset in mid-count", int'(tick_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) cyc <= cyc + 1;
endmodule